// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block holds the base/mode register of a per-processor interrupt controller. The register carries a global enable flag, an extended-mode flag, a bootstrap-processor flag and a 4 KB-aligned base address. Software writes a new image through a write strobe. The block checks each write against the present mode and the extended-mode support input. A write that passes is applied. A write that fails is dropped, and a one-cycle error flag is raised instead.

The register defines one of three operating modes: disabled, legacy, or extended. The block reports the mode and uses it to gate register accesses. The register-number interface works only in extended mode. In extended mode, writes to the registers that hold identity and destination formatting are refused. The block produces two side effects. When enable is cleared, it pulses a signal that tells the spurious-vector register to drop its software-enable bit. When extended mode is entered, it captures an extended logical ID that is derived from the processor ID.

Top module: `irq_base_mode_ctl`

## Requirements
- R1: After reset the register reads base 0xFEE00000 with enable (bit 11) set, extended (bit 10) clear, bootstrap (bit 8) equal to `bsp_strap_i`, all other bits zero. `mode_o` is legacy, `base_err_o` and `sw_en_clr_o` are 0, and `ext_ldr_o` is 0.
- R2: A write with `wr_extended_i`=1 while `ext_supported_i`=0 is rejected.
- R3: A write with `wr_enable_i`=0 and `wr_extended_i`=1 is rejected. `mode_o` never takes the value 2'b11.
- R4: A write from disabled mode requesting enable=1, extended=1 is rejected.
- R5: A write from extended mode requesting enable=1, extended=0 is rejected.
- R6: An accepted write loads `wr_base_i` into bits 31:12 and keeps bit 8 at the strap value. `mode_o` then follows the written flags: 2'b00 disabled (enable=0), 2'b01 legacy (enable=1, extended=0), 2'b10 extended (both 1).
- R7: A rejected write changes no field of `base_q_o`, `mode_o` or `ext_ldr_o`. It raises `base_err_o` for exactly the one cycle after the write edge.
- R8: An accepted write with enable=0 drives `sw_en_clr_o` high for exactly the one cycle after the write edge, and the mode becomes disabled.
- R9: On entry into extended mode, `ext_ldr_o` loads {`proc_id_i`[19:4], one-hot bit `proc_id_i`[3:0] in bits 15:0}. Accepted writes that stay in extended mode do not reload it.
- R10: A register-interface access (`acc_msr_i`=1) is granted only in extended mode. In other modes it is refused.
- R11: In extended mode, writes on either path to indices 0x02, 0x0D, 0x0E and 0x31 are refused. Reads of those indices and writes to other indices are granted. Memory-path accesses in legacy or disabled mode are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bsp_strap_i | input | 1 | Static bootstrap-processor strap |
| ext_supported_i | input | 1 | Extended mode is supported |
| proc_id_i | input | 20 | Processor ID used to derive the extended logical ID |
| base_wr_i | input | 1 | Base register write strobe |
| wr_base_i | input | 20 | Written base address bits 31:12 |
| wr_enable_i | input | 1 | Written enable flag |
| wr_extended_i | input | 1 | Written extended flag |
| base_q_o | output | 32 | Current register image |
| mode_o | output | 2 | Current mode: 00 disabled, 01 legacy, 10 extended |
| base_err_o | output | 1 | One-cycle pulse after a rejected write |
| sw_en_clr_o | output | 1 | One-cycle pulse to clear the spurious software-enable bit |
| ext_ldr_o | output | 32 | Extended logical ID |
| acc_vld_i | input | 1 | Register access request |
| acc_wr_i | input | 1 | Access is a write |
| acc_msr_i | input | 1 | Access uses the register-number interface (else memory path) |
| acc_idx_i | input | 8 | Register index |
| acc_ok_o | output | 1 | Access granted |
| acc_rej_o | output | 1 | Access refused |

## Verification
A corrupted enable or extended flag appears at once in `mode_o` and `base_q_o`. It also changes which later writes are refused, so the damage spreads to the error pulse on the next write and to the access grants in the same cycle. A wrong logical-ID capture surfaces only in `ext_ldr_o`. That is why the bench enters extended mode with a known processor ID, then changes the ID while staying in the mode, and reads the output one cycle after each write edge.

// File: rtl/irq_base_mode_pkg.sv
package irq_base_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_LEG = 2'b01,
    MODE_EXT = 2'b10
  } mode_e;
endpackage

// File: rtl/base_wr_check.sv
module base_wr_check (
  input  logic cur_en_i,
  input  logic cur_ext_i,
  input  logic wr_en_i,
  input  logic wr_ext_i,
  input  logic ext_sup_i,
  output logic reject_o
);
  logic no_sup, bad_combo, off_to_ext, ext_to_leg;

  always_comb begin
    no_sup     = wr_ext_i && !ext_sup_i;
    bad_combo  = !wr_en_i && wr_ext_i;
    off_to_ext = !cur_en_i && !cur_ext_i && wr_en_i && wr_ext_i;
    ext_to_leg = cur_en_i && cur_ext_i && wr_en_i && !wr_ext_i;
    reject_o   = no_sup || bad_combo || off_to_ext || ext_to_leg;
  end
endmodule

// File: rtl/ldr_gen.sv
module ldr_gen #(
  parameter int CLUSTER_W = 16,
  parameter int MEMB_W    = 16,
  localparam int SEL_W    = $clog2(MEMB_W),
  localparam int ID_W     = CLUSTER_W + SEL_W
) (
  input  logic [ID_W-1:0]             id_i,
  output logic [CLUSTER_W+MEMB_W-1:0] ldr_o
);
  logic [MEMB_W-1:0] memb;

  // one-hot member select
  for (genvar g = 0; g < MEMB_W; g++) begin : g_memb
    assign memb[g] = (id_i[SEL_W-1:0] == SEL_W'(g));
  end

  assign ldr_o = {id_i[ID_W-1:SEL_W], memb};
endmodule

// File: rtl/acc_gate.sv
module acc_gate
  import irq_base_mode_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int N_BLK   = 4,
  parameter logic [N_BLK-1:0][IDX_W-1:0] BLK_IDX = {8'h31, 8'h0E, 8'h0D, 8'h02}
) (
  input  mode_e            mode_i,
  input  logic             vld_i,
  input  logic             wr_i,
  input  logic             msr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             ok_o,
  output logic             rej_o
);
  logic [N_BLK-1:0] hit;
  logic             allow;

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    assign hit[g] = (idx_i == BLK_IDX[g]);
  end

  always_comb begin
    allow = 1'b1;
    if (msr_i && mode_i != MODE_EXT) allow = 1'b0;
    if (mode_i == MODE_EXT && wr_i && |hit) allow = 1'b0;
    ok_o  = vld_i && allow;
    rej_o = vld_i && !allow;
  end
endmodule

// File: rtl/base_state.sv
module base_state #(
  parameter int              ADDR_HI_W  = 20,
  parameter int              LDR_W      = 32,
  parameter logic [ADDR_HI_W-1:0] RST_ADDR = 20'hFEE00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 reject_i,
  input  logic [ADDR_HI_W-1:0] wr_addr_i,
  input  logic                 wr_en_i,
  input  logic                 wr_ext_i,
  input  logic [LDR_W-1:0]     ldr_next_i,
  output logic                 en_o,
  output logic                 ext_o,
  output logic [ADDR_HI_W-1:0] addr_o,
  output logic [LDR_W-1:0]     ldr_o,
  output logic                 err_o,
  output logic                 clr_o
);
  logic accept;
  assign accept = wr_i && !reject_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b1;
      ext_o  <= 1'b0;
      addr_o <= RST_ADDR;
      ldr_o  <= '0;
      err_o  <= 1'b0;
      clr_o  <= 1'b0;
    end else begin
      err_o <= wr_i && reject_i;
      clr_o <= accept && !wr_en_i;
      if (accept) begin
        addr_o <= wr_addr_i;
        en_o   <= wr_en_i;
        ext_o  <= wr_ext_i;
        // capture only on entry to extended mode
        if (!ext_o && wr_ext_i) ldr_o <= ldr_next_i;
      end
    end
  end
endmodule

// File: rtl/irq_base_mode_ctl.sv
module irq_base_mode_ctl
  import irq_base_mode_pkg::*;
#(
  parameter int BASE_W    = 32,
  parameter int BASE_LSB  = 12,
  parameter int EN_BIT    = 11,
  parameter int EXT_BIT   = 10,
  parameter int BSP_BIT   = 8,
  parameter logic [BASE_W-BASE_LSB-1:0] RST_ADDR = 20'hFEE00,
  parameter int CLUSTER_W = 16,
  parameter int MEMB_W    = 16,
  parameter int IDX_W     = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 bsp_strap_i,
  input  logic                                 ext_supported_i,
  input  logic [CLUSTER_W+$clog2(MEMB_W)-1:0]  proc_id_i,
  input  logic                                 base_wr_i,
  input  logic [BASE_W-BASE_LSB-1:0]           wr_base_i,
  input  logic                                 wr_enable_i,
  input  logic                                 wr_extended_i,
  output logic [BASE_W-1:0]                    base_q_o,
  output logic [1:0]                           mode_o,
  output logic                                 base_err_o,
  output logic                                 sw_en_clr_o,
  output logic [CLUSTER_W+MEMB_W-1:0]          ext_ldr_o,
  input  logic                                 acc_vld_i,
  input  logic                                 acc_wr_i,
  input  logic                                 acc_msr_i,
  input  logic [IDX_W-1:0]                     acc_idx_i,
  output logic                                 acc_ok_o,
  output logic                                 acc_rej_o
);
  localparam int ADDR_HI_W = BASE_W - BASE_LSB;
  localparam int LDR_W     = CLUSTER_W + MEMB_W;

  logic                 en_q, ext_q, reject;
  logic [ADDR_HI_W-1:0] addr_q;
  logic [LDR_W-1:0]     ldr_next;
  mode_e                mode;

  base_wr_check u_check (
    .cur_en_i  (en_q),
    .cur_ext_i (ext_q),
    .wr_en_i   (wr_enable_i),
    .wr_ext_i  (wr_extended_i),
    .ext_sup_i (ext_supported_i),
    .reject_o  (reject)
  );

  ldr_gen #(.CLUSTER_W(CLUSTER_W), .MEMB_W(MEMB_W)) u_ldr (
    .id_i  (proc_id_i),
    .ldr_o (ldr_next)
  );

  base_state #(.ADDR_HI_W(ADDR_HI_W), .LDR_W(LDR_W), .RST_ADDR(RST_ADDR)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (base_wr_i),
    .reject_i   (reject),
    .wr_addr_i  (wr_base_i),
    .wr_en_i    (wr_enable_i),
    .wr_ext_i   (wr_extended_i),
    .ldr_next_i (ldr_next),
    .en_o       (en_q),
    .ext_o      (ext_q),
    .addr_o     (addr_q),
    .ldr_o      (ext_ldr_o),
    .err_o      (base_err_o),
    .clr_o      (sw_en_clr_o)
  );

  always_comb begin
    if (ext_q)     mode = MODE_EXT;
    else if (en_q) mode = MODE_LEG;
    else           mode = MODE_OFF;
  end
  assign mode_o = mode;

  always_comb begin
    base_q_o                      = '0;
    base_q_o[BASE_W-1:BASE_LSB]   = addr_q;
    base_q_o[EN_BIT]              = en_q;
    base_q_o[EXT_BIT]             = ext_q;
    base_q_o[BSP_BIT]             = bsp_strap_i;
  end

  acc_gate #(.IDX_W(IDX_W)) u_gate (
    .mode_i (mode),
    .vld_i  (acc_vld_i),
    .wr_i   (acc_wr_i),
    .msr_i  (acc_msr_i),
    .idx_i  (acc_idx_i),
    .ok_o   (acc_ok_o),
    .rej_o  (acc_rej_o)
  );
endmodule

// File: rtl/irq_base_mode_chk.sv
module irq_base_mode_chk #(
  parameter int BASE_W = 32,
  parameter int LDR_W  = 32,
  parameter int MEMB_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_supported_i,
  input logic              base_wr_i,
  input logic              wr_enable_i,
  input logic              wr_extended_i,
  input logic [BASE_W-1:0] base_q_o,
  input logic [1:0]        mode_o,
  input logic              base_err_o,
  input logic              sw_en_clr_o,
  input logic [LDR_W-1:0]  ext_ldr_o,
  input logic              acc_vld_i,
  input logic              acc_msr_i,
  input logic              acc_ok_o,
  input logic              acc_rej_o
);
  // R7
  rej_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_err_o |-> $stable(base_q_o) && $stable(mode_o) && $stable(ext_ldr_o));
  // R2
  no_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i && wr_extended_i && !ext_supported_i |=> base_err_o);
  // R3
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);
  // R4
  off_to_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i && mode_o == 2'b00 && wr_enable_i && wr_extended_i |=> base_err_o);
  // R5
  ext_to_leg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i && mode_o == 2'b10 && wr_enable_i && !wr_extended_i |=> base_err_o && mode_o == 2'b10);
  // R8
  clr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_clr_o |-> mode_o == 2'b00 && !base_err_o);
  // R9
  ldr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == 2'b10) |-> $onehot(ext_ldr_o[MEMB_W-1:0]));
  // R10
  msr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_vld_i && acc_msr_i && mode_o != 2'b10 |-> acc_rej_o && !acc_ok_o);
endmodule

bind irq_base_mode_ctl irq_base_mode_chk #(
  .BASE_W(BASE_W), .LDR_W(CLUSTER_W + MEMB_W), .MEMB_W(MEMB_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_supported_i(ext_supported_i),
  .base_wr_i(base_wr_i), .wr_enable_i(wr_enable_i), .wr_extended_i(wr_extended_i),
  .base_q_o(base_q_o), .mode_o(mode_o), .base_err_o(base_err_o),
  .sw_en_clr_o(sw_en_clr_o), .ext_ldr_o(ext_ldr_o), .acc_vld_i(acc_vld_i),
  .acc_msr_i(acc_msr_i), .acc_ok_o(acc_ok_o), .acc_rej_o(acc_rej_o)
);

// File: tb/irq_base_mode_ctl_test.sv
module irq_base_mode_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsp_strap = 1'b1;
  logic        ext_sup = 1'b1;
  logic [19:0] proc_id = '0;
  logic        wr = 1'b0;
  logic [19:0] wr_base = '0;
  logic        wr_en = 1'b0, wr_ext = 1'b0;
  logic [31:0] base_q, ldr;
  logic [1:0]  mode;
  logic        err, clr;
  logic        a_vld = 1'b0, a_wr = 1'b0, a_msr = 1'b0;
  logic [7:0]  a_idx = '0;
  logic        a_ok, a_rej;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    logic [31:0] base;
    logic [1:0]  mode;
    logic        err;
    logic        clr;
    logic [31:0] ldr;
    string       tag;
  } item_t;
  item_t q[$];

  // bench-side register model
  logic        m_en = 1'b1, m_ext = 1'b0;
  logic [19:0] m_addr = 20'hFEE00;
  logic [31:0] m_ldr = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_base_mode_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .bsp_strap_i(bsp_strap), .ext_supported_i(ext_sup),
    .proc_id_i(proc_id), .base_wr_i(wr), .wr_base_i(wr_base), .wr_enable_i(wr_en),
    .wr_extended_i(wr_ext), .base_q_o(base_q), .mode_o(mode), .base_err_o(err),
    .sw_en_clr_o(clr), .ext_ldr_o(ldr), .acc_vld_i(a_vld), .acc_wr_i(a_wr),
    .acc_msr_i(a_msr), .acc_idx_i(a_idx), .acc_ok_o(a_ok), .acc_rej_o(a_rej)
  );

  function automatic logic [31:0] m_base();
    return {m_addr, m_en, m_ext, 1'b0, bsp_strap, 8'h00};
  endfunction
  function automatic logic [1:0] m_mode();
    return m_ext ? 2'b10 : (m_en ? 2'b01 : 2'b00);
  endfunction

  task automatic expect_now(bit e, bit c, string tag);
    item_t it;
    it.due = cyc + 1; it.base = m_base(); it.mode = m_mode();
    it.err = e; it.clr = c; it.ldr = m_ldr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_wr(logic [19:0] a, logic e, logic x, bit rej, string tag);
    @(negedge clk);
    wr = 1'b1; wr_base = a; wr_en = e; wr_ext = x;
    if (!rej) begin
      if (!m_ext && x) m_ldr = {proc_id[19:4], 16'(16'h1 << proc_id[3:0])};
      m_addr = a; m_en = e; m_ext = x;
    end
    expect_now(rej, !rej && !e, tag);
    @(negedge clk);
    wr = 1'b0;
    expect_now(1'b0, 1'b0, {tag, "_idle"});
  endtask

  task automatic acc_chk(logic w, logic m, logic [7:0] idx, bit exp_ok, string tag);
    @(negedge clk);
    a_vld = 1'b1; a_wr = w; a_msr = m; a_idx = idx;
    #1;
    checks++;
    if (a_ok !== exp_ok || a_rej !== !exp_ok) begin
      errors++;
      $display("FAIL %s: ok=%0b rej=%0b expected ok=%0b", tag, a_ok, a_rej, exp_ok);
    end
    a_vld = 1'b0;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (base_q !== it.base || mode !== it.mode || err !== it.err ||
          clr !== it.clr || ldr !== it.ldr) begin
        errors++;
        $display("FAIL %s: base=%h mode=%b err=%b clr=%b ldr=%h expected base=%h mode=%b err=%b clr=%b ldr=%h",
                 it.tag, base_q, mode, err, clr, ldr, it.base, it.mode, it.err, it.clr, it.ldr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (base_q !== 32'hFEE00900 || mode !== 2'b01 || err !== 1'b0 || clr !== 1'b0 || ldr !== 32'h0) begin
      errors++;
      $display("FAIL R1: base=%h mode=%b err=%b clr=%b ldr=%h expected base=fee00900 mode=01 err=0 clr=0 ldr=0",
               base_q, mode, err, clr, ldr);
    end

    ext_sup = 1'b0;
    do_wr(20'hABCDE, 1'b1, 1'b1, 1'b1, "R2_R7_no_support");
    ext_sup = 1'b1;
    do_wr(20'h11111, 1'b0, 1'b1, 1'b1, "R3_R7_bad_combo");
    do_wr(20'h12345, 1'b1, 1'b0, 1'b0, "R6_legacy_write");
    acc_chk(1'b1, 1'b0, 8'h02, 1'b1, "R11_leg_mem_id_wr");
    acc_chk(1'b0, 1'b1, 8'h08, 1'b0, "R10_leg_msr_rd");

    proc_id = 20'h30025;
    do_wr(20'h12345, 1'b1, 1'b1, 1'b0, "R9_R6_enter_ext");
    acc_chk(1'b0, 1'b1, 8'h08, 1'b1, "R10_ext_msr_rd");
    acc_chk(1'b1, 1'b1, 8'h02, 1'b0, "R11_ext_msr_id_wr");
    acc_chk(1'b1, 1'b0, 8'h0D, 1'b0, "R11_ext_mem_ldr_wr");
    acc_chk(1'b1, 1'b1, 8'h0E, 1'b0, "R11_ext_dfr_wr");
    acc_chk(1'b1, 1'b1, 8'h31, 1'b0, "R11_ext_icr_hi_wr");
    acc_chk(1'b0, 1'b1, 8'h0D, 1'b1, "R11_ext_ldr_rd");
    acc_chk(1'b1, 1'b1, 8'h30, 1'b1, "R11_ext_icr_lo_wr");

    do_wr(20'h22222, 1'b1, 1'b0, 1'b1, "R5_R7_ext_to_leg");
    proc_id = 20'h0000F;
    do_wr(20'h54321, 1'b1, 1'b1, 1'b0, "R9_stay_ext_no_reload");
    do_wr(20'h0ABCD, 1'b0, 1'b0, 1'b0, "R8_ext_to_off");
    acc_chk(1'b0, 1'b1, 8'h08, 1'b0, "R10_off_msr_rd");
    acc_chk(1'b1, 1'b0, 8'h0E, 1'b1, "R11_off_mem_dfr_wr");
    do_wr(20'h33333, 1'b1, 1'b1, 1'b1, "R4_R7_off_to_ext");
    do_wr(20'h0ABCD, 1'b0, 1'b0, 1'b0, "R8_off_to_off");
    do_wr(20'hFEE00, 1'b1, 1'b0, 1'b0, "R6_off_to_leg");
    do_wr(20'h77777, 1'b1, 1'b1, 1'b0, "R9_reenter_ext");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule